// File: doc/BRIEF.md
# Cascaded Third-Order Noise Shaper with Coarse/Fine Word Split

This block re-quantizes oversampled signed PCM samples into two short signed words per sample. A third-order error-feedback loop first reduces each sample to a 9-bit intermediate word. The loop's quantization error is filtered and subtracted from later inputs, so the noise transfer is (1 − z^-1)^3 and most of the noise sits far above the audio band.

A second, first-order error-feedback quantizer then cuts the 9-bit word into a 6-bit coarse word. The first difference of that coarse stage's error is emitted as a 6-bit fine word. A downstream stage adds the fine word at one sixteenth of the coarse weight, and this sum rebuilds the 9-bit word exactly. If the two weights do not match, only a first-order shaped part of the coarse error is left over.

The block advances its state only on an input strobe. Both words are registered and appear together with a valid flag one clock after the strobe. A sticky flag reports that the 9-bit stage had to clip.

Top module: `ns_shaper3`

## Requirements
- R1: A synchronous reset clears the output words to 0, drops the output valid flag and the overflow flag, and zeroes every error delay element. After reset, a zero input sample therefore yields coarse 0 and fine 0.
- R2: The output valid flag is high in exactly the cycle after a cycle in which the input strobe was high. New words appear together with that flag.
- R3: Every emitted pair satisfies 16·coarse + fine = 2·Y, where Y is the 9-bit intermediate word of R4. In other words, coarse + fine/16 equals Y/8, and the fine word is always even.
- R4: With stored errors e1, e2, e3 (newest first), the shaping loop computes u = x − (3·e1 − 3·e2 + e3). It then takes Y = floor(u / 2^15), limited as in R5, and stores the new error e = Y·2^15 − u.
- R5: Y is clipped to the range −256 … 247, so that the coarse stage can never exceed its 6-bit range. Any clip raises the overflow flag, which stays high until reset.
- R6: The coarse stage keeps its previous error p and forms w = Y − p. It emits coarse = floor(w / 8), stores the new error p' = 8·coarse − w (always between −7 and 0), and emits fine = 2·(p − p').
- R7: For a constant input held over 256 strobes, the sum of (16·coarse + fine)·2^14 differs from the sum of the inputs by at most 8·2^15.
- R8: While the strobe is low, the input word is ignored. The outputs hold their values and no error state advances, so the next strobed sample continues the sequence as if the idle cycles had not happened.
- R9: Each stored first-stage error is limited to −2^15 … 2^15−1. A clipped run is therefore followed by a bounded, stable recovery.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input sample strobe |
| in_sample | input | 24 | Signed input sample |
| out_valid | output | 1 | Output words valid |
| out_msb | output | 6 | Signed coarse word |
| out_lsb | output | 6 | Signed fine word (weight 1/16 of coarse) |
| ovf | output | 1 | Sticky intermediate clip flag |

## Verification
Each pattern below exercises a different part of the design:
- Runs of zeros show that reset leaves no stale error behind.
- Long positive and negative constants test that the low-frequency content tracks the input. They also confirm that the split words rebuild the intermediate word on every sample.
- An evenly spaced sweep from negative to positive full scale exercises every floor rounding case and both clip limits.
- A held positive full-scale input followed by silence tests the error limiting and the sticky flag.
- Strobe gaps carrying changing input words separate correct holding from silent state advance.
- A mid-run reset shows that the flag and all delay elements clear.

// File: rtl/ns_pkg.sv
package ns_pkg;
   // weight of the coarse word relative to the fine word
   localparam int unsigned NS_COARSE_TO_FINE = 16;
   localparam int unsigned NS_COARSE_TO_FINE_LOG2 = 4;
   // order of the first shaping loop (taps of the error delay line)
   localparam int unsigned NS_LOOP_TAPS = 3;
endpackage

// File: rtl/ns_ef3_loop.sv
module ns_ef3_loop #(
   parameter int W_IN  = 24,
   parameter int W_MID = 9,
   parameter int W_OUT = 6,
   parameter int W_ACC = 28
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    adv,
   input  logic signed [W_IN-1:0]  x,
   output logic signed [W_MID-1:0] y,
   output logic                    clip
);
   import ns_pkg::*;

   localparam int SH   = W_IN - W_MID;
   localparam int SH2  = W_MID - W_OUT;
   localparam int W_E  = SH + 2;
   localparam int Y_LO_I = -(1 << (W_MID - 1));
   localparam int Y_HI_I = (1 << (W_MID - 1)) - 1 - (1 << SH2);
   localparam logic signed [W_ACC-1:0] Y_LO = W_ACC'(Y_LO_I);
   localparam logic signed [W_ACC-1:0] Y_HI = W_ACC'(Y_HI_I);
   localparam logic signed [W_ACC-1:0] E_LO = -(W_ACC'(1) <<< SH);
   localparam logic signed [W_ACC-1:0] E_HI = (W_ACC'(1) <<< SH) - W_ACC'(1);

   if (W_ACC < W_IN + 4) begin : g_bad_acc
      $error("ns_ef3_loop: accumulator too narrow");
   end
   if (SH < 1) begin : g_bad_sh
      $error("ns_ef3_loop: intermediate word must be narrower than input");
   end

   logic signed [W_E-1:0]   e_dly [NS_LOOP_TAPS];
   logic signed [W_ACC-1:0] ea    [NS_LOOP_TAPS];
   logic signed [W_ACC-1:0] fb, u, q, y_full, e_raw, d01;
   logic signed [W_E-1:0]   e_new;

   always_comb begin
      for (int k = 0; k < NS_LOOP_TAPS; k++) begin
         ea[k] = W_ACC'(e_dly[k]);
      end
      d01 = ea[0] - ea[1];
      fb  = (d01 <<< 1) + d01 + ea[2];
      u   = W_ACC'(x) - fb;
      q   = u >>> SH;
      clip = (q < Y_LO) || (q > Y_HI);
      if (q < Y_LO)      y_full = Y_LO;
      else if (q > Y_HI) y_full = Y_HI;
      else               y_full = q;
      e_raw = (y_full <<< SH) - u;
      if (e_raw < E_LO)      e_new = E_LO[W_E-1:0];
      else if (e_raw > E_HI) e_new = E_HI[W_E-1:0];
      else                   e_new = e_raw[W_E-1:0];
   end

   assign y = y_full[W_MID-1:0];

   always_ff @(posedge clk) begin
      if (rst)      e_dly[0] <= '0;
      else if (adv) e_dly[0] <= e_new;
   end

   for (genvar t = 1; t < NS_LOOP_TAPS; t++) begin : g_tap
      always_ff @(posedge clk) begin
         if (rst)      e_dly[t] <= '0;
         else if (adv) e_dly[t] <= e_dly[t-1];
      end
   end
endmodule

// File: rtl/ns_split1.sv
module ns_split1 #(
   parameter int W_MID = 9,
   parameter int W_OUT = 6
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    adv,
   input  logic signed [W_MID-1:0] y,
   output logic signed [W_OUT-1:0] coarse,
   output logic signed [W_OUT-1:0] fine
);
   import ns_pkg::*;

   localparam int SH2    = W_MID - W_OUT;
   localparam int W_P    = SH2 + 1;
   localparam int LSB_SH = NS_COARSE_TO_FINE_LOG2 - SH2;

   if (SH2 < 1 || SH2 > NS_COARSE_TO_FINE_LOG2) begin : g_bad_sh2
      $error("ns_split1: unsupported word split");
   end

   logic signed [W_P-1:0]   p_q;
   logic signed [W_MID:0]   w, mw, e6w;
   logic signed [W_P-1:0]   e6;
   logic signed [W_OUT-1:0] d;

   always_comb begin
      w   = (W_MID+1)'(y) - (W_MID+1)'(p_q);
      mw  = w >>> SH2;
      e6w = (mw <<< SH2) - w;
      e6  = e6w[W_P-1:0];
      d   = W_OUT'(p_q) - W_OUT'(e6);
   end

   assign coarse = mw[W_OUT-1:0];

   if (LSB_SH == 0) begin : g_fine_direct
      assign fine = d;
   end else begin : g_fine_scaled
      assign fine = d <<< LSB_SH;
   end

   always_ff @(posedge clk) begin
      if (rst)      p_q <= '0;
      else if (adv) p_q <= e6;
   end
endmodule

// File: rtl/ns_shaper3.sv
module ns_shaper3 #(
   parameter int W_IN  = 24,
   parameter int W_MID = 9,
   parameter int W_OUT = 6,
   parameter int W_ACC = W_IN + 4
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             in_valid,
   input  logic [W_IN-1:0]  in_sample,
   output logic             out_valid,
   output logic [W_OUT-1:0] out_msb,
   output logic [W_OUT-1:0] out_lsb,
   output logic             ovf
);
   import ns_pkg::*;

   localparam int SH2    = W_MID - W_OUT;
   localparam int LSB_SH = NS_COARSE_TO_FINE_LOG2 - SH2;
   localparam int LSB_BOUND = ((1 << SH2) - 1) << LSB_SH;

   if (LSB_BOUND > (1 << (W_OUT - 1)) - 1) begin : g_bad_fine
      $error("ns_shaper3: fine word does not fit its width");
   end

   logic signed [W_MID-1:0] y_mid;
   logic                    clip;
   logic signed [W_OUT-1:0] coarse, fine;

   ns_ef3_loop #(.W_IN(W_IN), .W_MID(W_MID), .W_OUT(W_OUT), .W_ACC(W_ACC)) u_loop (
      .clk (clk),
      .rst (rst),
      .adv (in_valid),
      .x   ($signed(in_sample)),
      .y   (y_mid),
      .clip(clip)
   );

   ns_split1 #(.W_MID(W_MID), .W_OUT(W_OUT)) u_split (
      .clk   (clk),
      .rst   (rst),
      .adv   (in_valid),
      .y     (y_mid),
      .coarse(coarse),
      .fine  (fine)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         out_valid <= 1'b0;
         out_msb   <= '0;
         out_lsb   <= '0;
         ovf       <= 1'b0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            out_msb <= coarse;
            out_lsb <= fine;
            if (clip) ovf <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/ns_shaper3_chk.sv
module ns_shaper3_chk #(
   parameter int W_OUT     = 6,
   parameter int LSB_SH    = 1,
   parameter int LSB_BOUND = 14
) (
   input logic             clk,
   input logic             rst,
   input logic             in_valid,
   input logic             out_valid,
   input logic [W_OUT-1:0] out_msb,
   input logic [W_OUT-1:0] out_lsb,
   input logic             ovf
);
   localparam logic [W_OUT-1:0] GRID = W_OUT'((1 << LSB_SH) - 1);

   // R1
   p_reset_clear_r1: assert property (@(posedge clk)
      rst |=> (!out_valid && !ovf && out_msb == '0 && out_lsb == '0));

   // R2
   p_valid_follows_r2: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> out_valid);

   // R2, R8
   p_idle_hold_r8: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> (!out_valid && $stable(out_msb) && $stable(out_lsb)));

   // R3
   p_fine_grid_r3: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> ((out_lsb & GRID) == '0));

   // R6
   p_fine_bound_r6: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> ($signed(out_lsb) <= LSB_BOUND && $signed(out_lsb) >= -LSB_BOUND));

   // R5
   p_sticky_ovf_r5: assert property (@(posedge clk) disable iff (rst)
      ovf |=> ovf);
endmodule

bind ns_shaper3 ns_shaper3_chk #(
   .W_OUT(W_OUT), .LSB_SH(LSB_SH), .LSB_BOUND(LSB_BOUND)
) u_chk (
   .clk(clk), .rst(rst), .in_valid(in_valid), .out_valid(out_valid),
   .out_msb(out_msb), .out_lsb(out_lsb), .ovf(ovf)
);

// File: tb/sim_ns_shaper3.sv
module sim_ns_shaper3;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        in_valid = 1'b0;
   logic [23:0] in_sample = '0;
   logic        out_valid;
   logic [5:0]  out_msb, out_lsb;
   logic        ovf;

   always #(CLK_PERIOD/2) clk = ~clk;

   ns_shaper3 u0 (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
      .out_valid(out_valid), .out_msb(out_msb), .out_lsb(out_lsb), .ovf(ovf)
   );

   int checks = 0;
   int failures = 0;
   longint me1, me2, me3, mp;
   bit movf, clamp_seen;
   longint last_msb, last_lsb;
   longint sum_in, sum_out;

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic model_reset();
      me1 = 0; me2 = 0; me3 = 0; mp = 0; movf = 0; clamp_seen = 0;
      last_msb = 0; last_lsb = 0;
   endtask

   task automatic step(input longint x, input bit v);
      longint u, q, y, e, w, m, e6, lsb, am, al;
      in_sample = x[23:0];
      in_valid  = v;
      @(posedge clk);
      @(negedge clk);
      chk(out_valid == v, "R2 out_valid", longint'(out_valid), longint'(v));
      am = longint'($signed(out_msb));
      al = longint'($signed(out_lsb));
      if (v) begin
         u = x - (3*me1 - 3*me2 + me3);
         q = u >>> 15;
         y = q;
         if (q < -256) begin y = -256; movf = 1; end
         if (q > 247)  begin y = 247;  movf = 1; end
         e = y*32768 - u;
         if (e < -32768) begin e = -32768; clamp_seen = 1; end
         if (e > 32767)  begin e = 32767;  clamp_seen = 1; end
         me3 = me2; me2 = me1; me1 = e;
         w = y - mp;
         m = w >>> 3;
         e6 = m*8 - w;
         lsb = 2*(mp - e6);
         mp = e6;
         if (clamp_seen) chk(am == m, "R9 coarse after clamp", am, m);
         else            chk(am == m, "R4 R6 coarse", am, m);
         chk(al == lsb, "R6 fine", al, lsb);
         chk(16*am + al == 2*y, "R3 identity", 16*am + al, 2*y);
         last_msb = am; last_lsb = al;
         sum_in  += x;
         sum_out += (16*am + al) * 16384;
      end else begin
         chk(am == last_msb, "R8 coarse held", am, last_msb);
         chk(al == last_lsb, "R8 fine held", al, last_lsb);
      end
      chk(ovf == movf, "R5 ovf", longint'(ovf), longint'(movf));
      in_valid = 1'b0;
   endtask

   task automatic dc_track(input longint x);
      longint diff;
      for (int i = 0; i < 64; i++) step(x, 1'b1);
      sum_in = 0; sum_out = 0;
      for (int i = 0; i < 256; i++) step(x, 1'b1);
      diff = sum_out - sum_in;
      if (diff < 0) diff = -diff;
      chk(diff <= 8*32768, "R7 dc tracking", diff, 8*32768);
   endtask

   task automatic do_reset();
      rst = 1'b1;
      @(posedge clk);
      @(negedge clk);
      chk(out_valid == 1'b0, "R1 valid low", longint'(out_valid), 0);
      chk(ovf == 1'b0, "R1 ovf clear", longint'(ovf), 0);
      chk(out_msb == '0 && out_lsb == '0, "R1 words zero",
          longint'({out_msb, out_lsb}), 0);
      model_reset();
      rst = 1'b0;
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      failures++;
      $display("FAIL R2 watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      model_reset();
      sum_in = 0; sum_out = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      do_reset();
      // R1: zero input after reset
      for (int i = 0; i < 4; i++) step(0, 1'b1);
      // R8: idle cycles with changing data
      for (int i = 0; i < 3; i++) step(123456 + i*777777, 1'b0);
      // R7: constant inputs
      dc_track(1234567);
      dc_track(-3000000);
      // ramp with R8 gaps interleaved
      for (int i = 0; i < 200; i++) begin
         step(-2000000 + i*20011, 1'b1);
         if (i % 7 == 0) step(8388607 - i, 1'b0);
      end
      // full-scale sweep, R5 limits both sides
      for (int k = 0; k < 256; k++) step(-8388608 + k*65793, 1'b1);
      // R5, R9: held positive full scale then recovery
      for (int i = 0; i < 24; i++) step(8388607, 1'b1);
      for (int i = 0; i < 48; i++) step(0, 1'b1);
      for (int i = 0; i < 24; i++) step(-8388608, 1'b1);
      for (int i = 0; i < 48; i++) step(5000, 1'b1);
      // R1: reset mid-run clears flag and state
      do_reset();
      for (int i = 0; i < 3; i++) step(0, 1'b1);
      dc_track(77);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule